// File: doc/BRIEF.md
# Keypad Digit Capture Register

This block turns presses on a bank of eight active-low key lines into a dialled number. Seven of the lines carry the digits 0 to 6, and the eighth is a redial key. Every line is first filtered until it has stayed at one level long enough. A digit is taken when its key is let go. The new digit goes into the lowest BCD position, and every older digit moves one position toward the top. Once eight digits are held, the number is complete. At that moment the block also copies it into a saved-number register.

While the handset is lifted, a press of the redial key switches the digit outputs to the saved number. A clear request, such as a no-answer timeout from the call controller, empties the working number. Display scanning and call control belong to the neighbouring blocks.

A small state machine sets when digits may be accepted. Its states are:
- **ST_ONHOOK**: the handset is down.
- **ST_DIAL**: the handset is lifted and the number is not yet complete.
- **ST_FULL**: the handset is lifted and eight digits are held.

Its transitions are:
- **lift**: ST_ONHOOK to ST_DIAL, or to ST_FULL if eight digits are already held.
- **last_digit**: ST_DIAL to ST_FULL, when the eighth digit is accepted.
- **hang_up**: ST_DIAL or ST_FULL to ST_ONHOOK.
- **clear**: any state to ST_DIAL if the handset is lifted, otherwise to ST_ONHOOK.

Top module: `keypad_digit_capture`

## Requirements
- R1: Key lines 0 to 6 are active low and enter the digit equal to their index, as a 4-bit BCD value.
- R2: When several digit lines are low together, the lowest-numbered one gives the digit.
- R3: Line 7 is the redial key and never enters a digit or changes the digit count.
- R4: An accepted digit is placed in bits [3:0] of `digits`. The digit previously in position i moves to position i+1, which is bits [4i+7:4i+4]. The digit in position 7 is dropped.
- R5: `digit_count` rises by one per accepted digit. `entry_done` is high exactly when the count is 8. Digit presses are ignored while the count is 8.
- R6: A change on the key lines is taken only after the lines have held the same value for 25 consecutive clock samples. Shorter pulses have no effect.
- R7: One digit is accepted per press, when the filtered digit keys return to all-high. Holding a key longer enters no further digits.
- R8: A clear request sets all eight digits to 0, the count to 0 and `show_redial` to 0 on the next clock.
- R9: When the eighth digit is accepted, the complete number is saved. A redial press while off-hook sets `show_redial` and drives the saved number on `digits`. Hanging up, a clear request or an accepted digit drops `show_redial`.
- R10: While `off_hook` is low, digit presses and redial presses are ignored.
- R11: Digits are accepted only in ST_DIAL. After lifting the handset, ST_DIAL or ST_FULL is entered one clock later. A lift with eight digits held raises `entry_done` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_n | input | 8 | Raw key lines, active low; 0..6 digits, 7 redial |
| clear_req | input | 1 | Clear the working number |
| off_hook | input | 1 | High while the handset is lifted |
| digits | output | 32 | Eight BCD digits, position 0 in bits [3:0] |
| digit_count | output | 4 | Number of accepted digits, 0 to 8 |
| entry_done | output | 1 | Eight digits held |
| show_redial | output | 1 | `digits` shows the saved number |

## Verification
The assertions assume that `clear_req` and `off_hook` are clean synchronous levels. They also assume that a count increase comes only from a single accepted digit, never from two in one clock. The filter guarantees this, because any change takes at least 25 clocks to pass. The stimulus drives every input on the falling edge. It holds keys for either far more or far fewer than 25 samples, and it pulses `clear_req` for exactly one clock. This keeps every scenario within those assumptions.

// File: rtl/kd_pkg.sv
package kd_pkg;
    typedef enum logic [1:0] {
        ST_ONHOOK = 2'd0,
        ST_DIAL   = 2'd1,
        ST_FULL   = 2'd2
    } dial_state_t;
endpackage

// File: rtl/kd_debounce.sv
module kd_debounce #(
    parameter int W      = 8,
    parameter int STABLE = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] clean
);
    localparam int CW = $clog2(STABLE + 1);

    logic [W-1:0]  samp;
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp  <= '1;
            run   <= '0;
            clean <= '1;
        end else begin
            samp <= raw;
            if (raw != samp) begin
                run <= CW'(1);
            end else if (run < CW'(STABLE)) begin
                run <= run + 1'b1;
            end
            if (raw == samp && run >= CW'(STABLE - 1)) begin
                clean <= raw;
            end
        end
    end
endmodule

// File: rtl/kd_key_events.sv
module kd_key_events #(
    parameter int NUM_KEYS = 8,
    parameter int DW       = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] clean,
    output logic                rel_pulse,
    output logic [DW-1:0]       rel_digit,
    output logic                redial_press
);
    localparam int NDK = NUM_KEYS - 1;
    localparam int RED = NUM_KEYS - 1;

    logic [NUM_KEYS-1:0] prev;

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= clean;
    end

    // lowest-numbered low key of the held pattern wins
    always_comb begin
        rel_digit = '0;
        for (int i = NDK - 1; i >= 0; i--) begin
            if (!prev[i]) rel_digit = DW'(i);
        end
    end

    assign rel_pulse    = (~&prev[NDK-1:0]) && (&clean[NDK-1:0]);
    assign redial_press = prev[RED] && !clean[RED];
endmodule

// File: rtl/kd_digit_store.sv
module kd_digit_store #(
    parameter int NUM_DIGITS = 8,
    parameter int DW         = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     shift_en,
    input  logic [DW-1:0]            din,
    output logic [NUM_DIGITS*DW-1:0] work,
    output logic [NUM_DIGITS*DW-1:0] saved,
    output logic [$clog2(NUM_DIGITS+1)-1:0] count
);
    localparam int TOT = NUM_DIGITS * DW;
    localparam int CW  = $clog2(NUM_DIGITS + 1);

    logic [TOT-1:0] shifted;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_lane
        if (g == 0) begin : g_in
            assign shifted[DW-1:0] = din;
        end else begin : g_mv
            assign shifted[g*DW +: DW] = work[(g-1)*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work  <= '0;
            saved <= '0;
            count <= '0;
        end else if (clear) begin
            work  <= '0;
            count <= '0;
        end else if (shift_en) begin
            work  <= shifted;
            count <= count + 1'b1;
            if (count == CW'(NUM_DIGITS - 1)) saved <= shifted;
        end
    end
endmodule

// File: rtl/keypad_digit_capture.sv
module keypad_digit_capture #(
    parameter int NUM_DIGITS    = 8,
    parameter int DIGIT_W       = 4,
    parameter int NUM_KEYS      = 8,
    parameter int STABLE_CYCLES = 25
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_KEYS-1:0]               key_n,
    input  logic                              clear_req,
    input  logic                              off_hook,
    output logic [NUM_DIGITS*DIGIT_W-1:0]     digits,
    output logic [$clog2(NUM_DIGITS+1)-1:0]   digit_count,
    output logic                              entry_done,
    output logic                              show_redial
);
    import kd_pkg::*;

    localparam int TOT = NUM_DIGITS * DIGIT_W;
    localparam int CW  = $clog2(NUM_DIGITS + 1);

    logic [NUM_KEYS-1:0] clean;
    logic                rel_pulse, redial_press, accept, last_digit, full;
    logic [DIGIT_W-1:0]  rel_digit;
    logic [TOT-1:0]      work, saved;
    dial_state_t         state, state_nx;

    kd_debounce #(.W(NUM_KEYS), .STABLE(STABLE_CYCLES)) u_deb (
        .clk(clk), .rst_n(rst_n), .raw(key_n), .clean(clean)
    );

    kd_key_events #(.NUM_KEYS(NUM_KEYS), .DW(DIGIT_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .clean(clean),
        .rel_pulse(rel_pulse), .rel_digit(rel_digit), .redial_press(redial_press)
    );

    kd_digit_store #(.NUM_DIGITS(NUM_DIGITS), .DW(DIGIT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear_req), .shift_en(accept),
        .din(rel_digit), .work(work), .saved(saved), .count(digit_count)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ONHOOK;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (clear_req) begin
            state_nx = off_hook ? ST_DIAL : ST_ONHOOK;
        end else begin
            unique case (state)
                ST_ONHOOK: if (off_hook) state_nx = full ? ST_FULL : ST_DIAL;
                ST_DIAL: begin
                    if (!off_hook)       state_nx = ST_ONHOOK;
                    else if (last_digit) state_nx = ST_FULL;
                end
                ST_FULL:   if (!off_hook) state_nx = ST_ONHOOK;
                default:   state_nx = ST_ONHOOK;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        full       = (digit_count == CW'(NUM_DIGITS));
        accept     = rel_pulse && off_hook && !clear_req && (state == ST_DIAL);
        last_digit = accept && (digit_count == CW'(NUM_DIGITS - 1));
        entry_done = full;
        digits     = show_redial ? saved : work;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                      show_redial <= 1'b0;
        else if (clear_req || !off_hook) show_redial <= 1'b0;
        else if (accept)                 show_redial <= 1'b0;
        else if (redial_press)           show_redial <= 1'b1;
    end
endmodule

// File: rtl/kd_capture_chk.sv
module kd_capture_chk #(
    parameter int NUM_DIGITS = 8,
    parameter int DIGIT_W    = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            clear_req,
    input logic                            off_hook,
    input logic [NUM_DIGITS*DIGIT_W-1:0]   digits,
    input logic [$clog2(NUM_DIGITS+1)-1:0] digit_count,
    input logic                            entry_done,
    input logic                            show_redial
);
    localparam int TOT = NUM_DIGITS * DIGIT_W;
    localparam int CW  = $clog2(NUM_DIGITS + 1);

    // R5
    count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit_count <= CW'(NUM_DIGITS));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_done && !clear_req) |=> entry_done);

    // R8
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (digit_count == '0 && digits == '0 && !show_redial));

    // R10
    onhook_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!off_hook && !clear_req) |=> $stable(digit_count));

    // R9
    hangup_redial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !off_hook |=> !show_redial);

    // R4
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_req && !show_redial) ##1
        (!show_redial && digit_count == $past(digit_count) + CW'(1))
        |-> digits[TOT-1:DIGIT_W] == $past(digits[TOT-DIGIT_W-1:0]));
endmodule

bind keypad_digit_capture kd_capture_chk #(
    .NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clear_req(clear_req), .off_hook(off_hook),
    .digits(digits), .digit_count(digit_count), .entry_done(entry_done),
    .show_redial(show_redial)
);

// File: tb/keypad_digit_capture_test.sv
`timescale 1ns/1ps
module keypad_digit_capture_test;
    localparam int S = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  key_n = 8'hFF;
    logic        clear_req = 1'b0;
    logic        off_hook = 1'b0;
    logic [31:0] digits;
    logic [3:0]  digit_count;
    logic        entry_done, show_redial;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    keypad_digit_capture uut (
        .clk(clk), .rst_n(rst_n), .key_n(key_n), .clear_req(clear_req),
        .off_hook(off_hook), .digits(digits), .digit_count(digit_count),
        .entry_done(entry_done), .show_redial(show_redial)
    );

    // behavioural reference model
    logic [7:0] m_samp, m_clean, m_prev;
    int m_run, m_cnt;
    bit m_hook, m_show;
    int m_work[8];
    int m_saved[8];

    function automatic logic [31:0] pack(input int a[8]);
        logic [31:0] v = '0;
        for (int i = 0; i < 8; i++) v[i*4 +: 4] = a[i][3:0];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_samp = 8'hFF; m_clean = 8'hFF; m_prev = 8'hFF;
            m_run = 0; m_cnt = 0; m_hook = 0; m_show = 0;
            for (int i = 0; i < 8; i++) begin m_work[i] = 0; m_saved[i] = 0; end
        end else begin
            bit rel, red, acc;
            int rd;
            rel = (m_prev[6:0] != 7'h7F) && (m_clean[6:0] == 7'h7F);
            rd = 0;
            for (int i = 6; i >= 0; i--) if (!m_prev[i]) rd = i;
            red = m_prev[7] && !m_clean[7];
            acc = rel && off_hook && m_hook && (m_cnt < 8) && !clear_req;
            if (clear_req) begin
                for (int i = 0; i < 8; i++) m_work[i] = 0;
                m_cnt = 0;
            end else if (acc) begin
                for (int i = 7; i > 0; i--) m_work[i] = m_work[i-1];
                m_work[0] = rd;
                m_cnt++;
                if (m_cnt == 8) m_saved = m_work;
            end
            if (clear_req || !off_hook || acc) m_show = 0;
            else if (red) m_show = 1;
            m_prev = m_clean;
            if (key_n == m_samp && m_run >= S - 1) m_clean = key_n;
            if (key_n != m_samp) m_run = 1;
            else if (m_run < S) m_run++;
            m_samp = key_n;
            m_hook = off_hook;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [31:0] ed;
            ed = m_show ? pack(m_saved) : pack(m_work);
            checks++;
            if (digits !== ed) begin
                errors++;
                $display("FAIL R4 digits actual=%h expected=%h", digits, ed);
            end
            checks++;
            if (digit_count !== 4'(m_cnt) || entry_done !== (m_cnt == 8)) begin
                errors++;
                $display("FAIL R5 count/done actual=%0d/%0b expected=%0d/%0b",
                         digit_count, entry_done, m_cnt, m_cnt == 8);
            end
            checks++;
            if (show_redial !== m_show) begin
                errors++;
                $display("FAIL R9 show_redial actual=%0b expected=%0b", show_redial, m_show);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic press(input logic [7:0] low_mask, input int hold, input int gap);
        key_n = ~low_mask;
        repeat (hold) @(negedge clk);
        key_n = 8'hFF;
        repeat (gap) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset digits", digits, 32'h0);
        chk("R5 reset count", {28'h0, digit_count}, 32'h0);
        // R10: on-hook press ignored
        press(8'h10, 40, 40);
        chk("R10 onhook digit", {28'h0, digit_count}, 32'h0);
        press(8'h80, 40, 40);
        chk("R10 onhook redial", {31'h0, show_redial}, 32'h0);
        off_hook = 1'b1;
        repeat (2) @(negedge clk);
        press(8'h08, 40, 40);                 // 3 (R1)
        press(8'h12, 40, 40);                 // keys 1 and 4 -> 1 (R2)
        chk("R2 priority", digits, 32'h31);
        press(8'h80, 40, 40);                 // redial key, no digit (R3)
        chk("R3 redial no digit", {28'h0, digit_count}, 32'h2);
        press(8'h10, 40, 40);                 // 4
        press(8'h02, 40, 40);                 // 1
        press(8'h20, 40, 40);                 // 5
        press(8'h04, 40, 40);                 // 2
        press(8'h40, 40, 40);                 // 6
        press(8'h01, 40, 40);                 // 0
        chk("R4 R1 full number", digits, 32'h31415260);
        chk("R5 done", {31'h0, entry_done}, 32'h1);
        press(8'h40, 40, 40);
        chk("R5 ninth ignored", digits, 32'h31415260);
        off_hook = 1'b0;
        repeat (5) @(negedge clk);
        off_hook = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 relift full", {31'h0, entry_done}, 32'h1);
        clear_req = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        chk("R8 clear", {digits[31:4], digit_count}, 32'h0);
        press(8'h04, 10, 40);                 // short glitch
        chk("R6 glitch ignored", {28'h0, digit_count}, 32'h0);
        press(8'h20, 120, 40);                // long hold -> one digit
        chk("R7 one per press", {28'h0, digit_count}, 32'h1);
        chk("R7 digit value", digits, 32'h5);
        press(8'h80, 40, 40);
        chk("R9 redial shown", digits, 32'h31415260);
        press(8'h08, 40, 40);
        chk("R9 digit drops redial", digits, 32'h53);
        press(8'h80, 40, 40);
        chk("R9 redial again", {31'h0, show_redial}, 32'h1);
        off_hook = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 hangup drops", {31'h0, show_redial}, 32'h0);
        off_hook = 1'b1;
        @(negedge clk);
        chk("R11 dial resumes", {28'h0, digit_count}, 32'h2);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule